// File: doc/BRIEF.md
# Clocked Synchronous Serial Unit

This block moves whole bytes over a three-wire synchronous serial link: a serial clock, a data output and a data input. Each transfer is exactly eight data bits, least significant bit first, with no start, stop or parity bits. The block drives its data output on the falling edge of the serial clock and samples its data input on the rising edge. Bytes to send are queued in a 16-entry transmit FIFO, and bytes received are queued in a 16-entry receive FIFO.

One select pin sets where the serial clock comes from. With the select low, the block is the clock master. It divides the system clock, drives the result on `sclk_out` and enables `sclk_oe`. That clock idles high and runs only while a byte is being sent, so it pauses whenever the transmit FIFO runs dry. With the select high, the block follows `sclk_in`, which passes through a two-flop synchronizer. That input must run at no more than a quarter of the system clock. In this mode the internal divider is idle, and a frame with nothing queued shifts out all ones.

Both data sides use valid/ready. On the transmit side, a byte is taken on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` drops while the FIFO holds 16 bytes, and the producer must hold its byte until it is accepted. On the receive side, `rx_valid` is high whenever a byte is stored. `rx_data` holds still until a clock edge where `rx_ready` is high. A byte that completes while the receive FIFO is full is dropped, and it sets a sticky overrun flag that only reset clears.

Top module: `sync_serial_unit`

## Requirements
- R1: Every frame carries exactly 8 data bits, least significant bit first, with one rising serial-clock edge per bit and no framing or parity bits.
- R2: `sd_out` changes only at a falling edge of the serial clock, and `sd_in` is sampled at a rising edge.
- R3: With `ext_clk_sel` low, `sclk_oe` is 1. `sclk_out` idles high, each low phase lasts DIV system clocks (8*DIV low cycles per byte), and the clock stops high between bytes while the transmit FIFO is empty.
- R4: With `ext_clk_sel` high, `sclk_oe` is 0 and the internal divider is idle. No bit moves unless `sclk_in` toggles, and shifting follows `sclk_in` edges once synchronized.
- R5: The transmit FIFO holds 16 bytes. `tx_count` reports its fill level, and `tx_ready` is 0 exactly when it is full.
- R6: The receive FIFO holds 16 bytes in arrival order. `rx_count` reports its fill level, `rx_valid` is 1 when it is non-empty, and `rx_data` is stable until it is popped.
- R7: A byte that completes while the receive FIFO is full is dropped and sets `overrun`. The flag stays 1 until reset.
- R8: In external-clock mode, a frame that starts with the transmit FIFO empty shifts out 8 ones (0xFF).
- R9: After reset, both counts are 0, `overrun` is 0, `rx_valid` is 0, `tx_ready` is 1, `sclk_out` is 1 and `sd_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk_sel | input | 1 | 0: drive the serial clock; 1: follow `sclk_in` |
| sclk_in | input | 1 | External serial clock |
| sclk_out | output | 1 | Generated serial clock (idles high) |
| sclk_oe | output | 1 | Output enable for `sclk_out` |
| sd_out | output | 1 | Serial data out |
| sd_in | input | 1 | Serial data in |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit FIFO can accept a byte |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Receive byte available |
| rx_ready | input | 1 | Consumer takes the receive byte |
| rx_data | output | 8 | Oldest received byte |
| tx_count | output | $clog2(FIFO_DEPTH+1) | Transmit FIFO fill level |
| rx_count | output | $clog2(FIFO_DEPTH+1) | Receive FIFO fill level |
| overrun | output | 1 | Sticky receive overrun flag |

## Verification
The bench uses the default build: FIFO_DEPTH 16 and DIV 4. A half-period of four system clocks keeps each master-mode frame short, so a looped-back byte table runs quickly while still checking an exact count of low-phase cycles. The 16-entry depth allows a FIFO to be filled completely. An external master running at one sixteenth of the system clock then pushes a seventeenth frame into a full receive FIFO. That same run drains the full transmit FIFO and reaches the all-ones frame sent when nothing is queued.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned BIT_CW  = $clog2(BYTE_W);
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/ssu_fifo.sv
module ssu_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [W-1:0]               in_data,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [W-1:0]               out_data,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;
  logic          push, pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign in_ready  = (cnt_q != CW'(DEPTH));
  assign out_valid = (cnt_q != '0);
  assign out_data  = mem[rd_ptr];
  assign count     = cnt_q;
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/ssu_clkgen.sv
module ssu_clkgen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_sel,
  input  logic sclk_in,
  input  logic tx_avail,
  input  logic frame_idle,
  output logic sclk_out,
  output logic rise_p,
  output logic fall_p
);
  localparam int unsigned CNTW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CNTW-1:0] cnt;
  logic            sclk_q;
  logic            hold, tick;
  logic            s1, s2, s3;

  // master clock parks high at a frame boundary with nothing to send
  assign hold = sclk_q && frame_idle && !tx_avail;
  assign tick = !ext_sel && !hold && (cnt == CNTW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sclk_q <= 1'b1;
    end else if (ext_sel || hold) begin
      cnt    <= '0;
      sclk_q <= 1'b1;
    end else if (tick) begin
      cnt    <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt    <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {s1, s2, s3} <= 3'b111;
    else        {s1, s2, s3} <= {sclk_in, s1, s2};
  end

  assign sclk_out = sclk_q;
  assign rise_p   = ext_sel ? (s2 && !s3) : (tick && !sclk_q);
  assign fall_p   = ext_sel ? (!s2 && s3) : (tick && sclk_q);
endmodule

// File: rtl/ssu_shifter.sv
module ssu_shifter
  import ssu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_p,
  input  logic              fall_p,
  input  logic              sd_in,
  input  logic              tx_avail,
  input  byte_t             tx_byte,
  output logic              tx_pop,
  output logic              sd_out,
  output logic              rx_push,
  output byte_t             rx_byte,
  output logic [BIT_CW-1:0] bit_idx
);
  byte_t txsh, rxsh;
  logic  at_start;

  assign at_start = (bit_idx == '0);
  assign tx_pop   = fall_p && at_start && tx_avail;
  assign rx_byte  = rxsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_out  <= 1'b1;
      txsh    <= '1;
      rxsh    <= '0;
      bit_idx <= '0;
      rx_push <= 1'b0;
    end else begin
      rx_push <= 1'b0;
      if (fall_p) begin
        if (at_start) begin
          // load a queued byte, or send ones when nothing is queued
          sd_out <= tx_avail ? tx_byte[0] : 1'b1;
          txsh   <= tx_avail ? {1'b1, tx_byte[BYTE_W-1:1]} : '1;
        end else begin
          sd_out <= txsh[0];
          txsh   <= {1'b1, txsh[BYTE_W-1:1]};
        end
      end
      if (rise_p) begin
        rxsh <= {sd_in, rxsh[BYTE_W-1:1]};
        if (bit_idx == BIT_CW'(BYTE_W - 1)) begin
          bit_idx <= '0;
          rx_push <= 1'b1;
        end else begin
          bit_idx <= bit_idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sync_serial_unit.sv
module sync_serial_unit #(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned DIV        = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ext_clk_sel,
  input  logic                            sclk_in,
  output logic                            sclk_out,
  output logic                            sclk_oe,
  output logic                            sd_out,
  input  logic                            sd_in,
  input  logic                            tx_valid,
  output logic                            tx_ready,
  input  logic [7:0]                      tx_data,
  output logic                            rx_valid,
  input  logic                            rx_ready,
  output logic [7:0]                      rx_data,
  output logic [$clog2(FIFO_DEPTH+1)-1:0] tx_count,
  output logic [$clog2(FIFO_DEPTH+1)-1:0] rx_count,
  output logic                            overrun
);
  import ssu_pkg::*;

  logic              tx_avail, tx_pop, rx_push, rx_in_ready;
  byte_t             tx_head, rx_byte;
  logic              rise_p, fall_p;
  logic [BIT_CW-1:0] bit_idx;

  ssu_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(tx_valid), .in_ready(tx_ready), .in_data(tx_data),
    .out_valid(tx_avail), .out_ready(tx_pop), .out_data(tx_head),
    .count(tx_count)
  );

  ssu_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_push), .in_ready(rx_in_ready), .in_data(rx_byte),
    .out_valid(rx_valid), .out_ready(rx_ready), .out_data(rx_data),
    .count(rx_count)
  );

  ssu_clkgen #(.DIV(DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .ext_sel(ext_clk_sel), .sclk_in(sclk_in),
    .tx_avail(tx_avail), .frame_idle(bit_idx == '0),
    .sclk_out(sclk_out), .rise_p(rise_p), .fall_p(fall_p)
  );

  ssu_shifter u_shf (
    .clk(clk), .rst_n(rst_n), .rise_p(rise_p), .fall_p(fall_p),
    .sd_in(sd_in), .tx_avail(tx_avail), .tx_byte(tx_head), .tx_pop(tx_pop),
    .sd_out(sd_out), .rx_push(rx_push), .rx_byte(rx_byte), .bit_idx(bit_idx)
  );

  assign sclk_oe = !ext_clk_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       overrun <= 1'b0;
    else if (rx_push && !rx_in_ready) overrun <= 1'b1;
  end
endmodule

// File: rtl/ssu_checker.sv
module ssu_checker #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ext_clk_sel,
  input logic          sclk_out,
  input logic          sd_out,
  input logic          tx_ready,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic [7:0]    rx_data,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count,
  input logic          overrun,
  input logic [2:0]    bit_idx
);
  a_r2_out_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_clk_sel && $past(!ext_clk_sel) && !$stable(sd_out)) |-> $fell(sclk_out));

  a_r3_park_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_clk_sel && sclk_out && bit_idx == 3'd0 && tx_count == '0) |=> sclk_out);

  a_r5_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == CW'(DEPTH)) |-> !tx_ready);

  a_r5_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= CW'(DEPTH));

  a_r6_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH));

  a_r6_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> $stable(rx_data));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  a_r7_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rx_count) == CW'(DEPTH));
endmodule

bind sync_serial_unit ssu_checker #(
  .DEPTH(FIFO_DEPTH), .CW($clog2(FIFO_DEPTH+1))
) i_ssu_checker (
  .clk(clk), .rst_n(rst_n), .ext_clk_sel(ext_clk_sel), .sclk_out(sclk_out),
  .sd_out(sd_out), .tx_ready(tx_ready), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .rx_data(rx_data), .tx_count(tx_count),
  .rx_count(rx_count), .overrun(overrun), .bit_idx(bit_idx)
);

// File: tb/test_sync_serial_unit.sv
module test_sync_serial_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int DIV        = 4;
  localparam int HALF       = 8;
  localparam int NV         = 8;
  localparam logic [7:0] VEC [NV] =
    '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80, 8'h3C, 8'hC3};

  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_clk_sel = 1'b0, sclk_in = 1'b1, sd_m = 1'b0;
  logic tx_valid = 1'b0, rx_ready = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic sclk_out, sclk_oe, sd_out, sd_in, tx_ready, rx_valid, overrun;
  logic [7:0] rx_data;
  logic [4:0] tx_count, rx_count;

  int compared = 0, mismatched = 0;
  bit mon_en = 1'b0;
  logic [7:0] mon_shift = 8'h00;
  int low_cycles = 0;
  logic [7:0] got_tx [DEPTH+1];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sd_in = ext_clk_sel ? sd_m : sd_out;

  sync_serial_unit #(.FIFO_DEPTH(DEPTH), .DIV(DIV)) i_sync_serial_unit (
    .clk(clk), .rst_n(rst_n), .ext_clk_sel(ext_clk_sel), .sclk_in(sclk_in),
    .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sd_out(sd_out), .sd_in(sd_in),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_count(tx_count), .rx_count(rx_count), .overrun(overrun)
  );

  always @(posedge sclk_out) if (mon_en) mon_shift = {sd_out, mon_shift[7:1]};
  always @(negedge clk) if (mon_en && !sclk_out) low_cycles++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = b;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pop_rx(output logic [7:0] b, output bit ok);
    int n = 0;
    @(negedge clk);
    while (!rx_valid && n < 1000) begin @(negedge clk); n++; end
    ok = rx_valid;
    b = rx_data;
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic master_frame(input logic [7:0] send, output logic [7:0] got);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      sclk_in = 1'b0; sd_m = send[i];
      repeat (HALF) @(negedge clk);
      sclk_in = 1'b1; got[i] = sd_out;
      repeat (HALF) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [7:0] b;
    bit ok;
    int lc0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(tx_count == 0, "R9 tx_count", tx_count, 0);
    check(rx_count == 0, "R9 rx_count", rx_count, 0);
    check(overrun == 0 && rx_valid == 0, "R9 flags", {overrun, rx_valid}, 0);
    check(tx_ready == 1 && sclk_out == 1 && sd_out == 1, "R9 idle pins",
          {tx_ready, sclk_out, sd_out}, 3'b111);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    mon_en = 1'b1;
    check(sclk_oe == 1, "R3 oe master", sclk_oe, 1);

    // master-mode loopback table
    for (int v = 0; v < NV; v++) begin
      lc0 = low_cycles;
      push_tx(VEC[v]);
      pop_rx(b, ok);
      check(ok && b == VEC[v], "R1/R6 loopback byte", b, VEC[v]);
      check(mon_shift == VEC[v], "R1/R2 lsb-first line bits", mon_shift, VEC[v]);
      check(low_cycles - lc0 == 8*DIV, "R3 low phase cycles", low_cycles - lc0, 8*DIV);
    end

    // R3 clock parks high with empty transmit FIFO
    begin
      int hi = 0;
      for (int k = 0; k < 100; k++) begin @(negedge clk); if (sclk_out) hi++; end
      check(hi == 100, "R3 paused high", hi, 100);
    end

    // external-clock mode: fill transmit FIFO with no serial clock
    mon_en = 1'b0;
    @(negedge clk); ext_clk_sel = 1'b1;
    @(negedge clk);
    check(sclk_oe == 0, "R4 oe released", sclk_oe, 0);
    for (int i = 0; i < DEPTH; i++) push_tx(8'((i * 29 + 3) & 255));
    repeat (50) @(negedge clk);
    check(tx_count == DEPTH, "R4/R5 no shifting, fifo full", tx_count, DEPTH);
    check(tx_ready == 0, "R5 tx_ready low when full", tx_ready, 0);

    for (int f = 0; f < DEPTH; f++) master_frame(8'((f * 37 + 11) & 255), got_tx[f]);
    repeat (10) @(negedge clk);
    check(rx_count == DEPTH, "R6 rx_count full", rx_count, DEPTH);
    check(overrun == 0, "R7 no early overrun", overrun, 0);
    check(tx_count == 0, "R5 tx drained", tx_count, 0);
    master_frame(8'h77, got_tx[DEPTH]);
    repeat (10) @(negedge clk);
    check(overrun == 1, "R7 overrun set", overrun, 1);
    check(rx_count == DEPTH, "R7 byte dropped", rx_count, DEPTH);
    check(got_tx[DEPTH] == 8'hFF, "R8 empty frame all ones", got_tx[DEPTH], 8'hFF);
    for (int f = 0; f < DEPTH; f++)
      check(got_tx[f] == 8'((f * 29 + 3) & 255), "R4 ext tx byte", got_tx[f], (f * 29 + 3) & 255);
    for (int f = 0; f < DEPTH; f++) begin
      pop_rx(b, ok);
      check(ok && b == 8'((f * 37 + 11) & 255), "R6/R7 rx order", b, (f * 37 + 11) & 255);
    end
    @(negedge clk);
    check(rx_valid == 0, "R6 rx empty", rx_valid, 0);
    check(overrun == 1, "R7 sticky after drain", overrun, 1);

    // reset clears the sticky flag
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(overrun == 0 && rx_count == 0, "R9/R7 cleared by reset", {overrun, rx_count}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule